// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital side of a 10-bit successive-approximation analog-to-digital converter. A processor programs it through a small register window. The window holds one control/status byte and four result registers. A conversion starts when software sets the start bit or when a rising edge arrives on the external trigger pin. The block then walks a trial code out to a DAC and reads back a single comparator bit. At the end it stores the code in the result register for the converted channel and flags completion.

The analog multiplexer, the DAC and the comparator sit outside the block. The block tells the multiplexer which channel to present (`ana_ch`), drives the trial code (`dac_code`) and samples `cmp_ge`. `cmp_ge` is high when the analog input is at or above the DAC level.

The block has two modes. In single mode it converts one channel once and then goes idle. In scan mode it cycles through channels 0 up to the selected channel, over and over, until software clears the start bit.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset the following all read 0: the control byte, all four result registers, `irq`, `dac_code` and `ana_ch`.
- R2: A conversion decides one bit per clock, starting at bit 9 and ending at bit 0. Each trial bit is kept when `cmp_ge` is 1. With an ideal comparator the stored result is min(input level, 1023). It becomes visible 11 clock edges after the edge that accepted the start.
- R3: The start bit reads 1 for the whole conversion. In single mode it clears by itself on the edge that stores the result.
- R4: The done flag rises on the same edge that writes the result. The result goes into register number (channel mod 4).
- R5: `irq` is high exactly while the done flag and the interrupt-enable bit are both 1.
- R6: Writing 0 to the done flag clears it only if the control byte was read, with done at 1, after the previous control write. Otherwise the flag stays set. Writing 1 to the done flag never sets it.
- R7: Writing 0 to the start bit during a conversion aborts it. No result register changes and done stays 0.
- R8: The trigger pin passes through a two-flop synchronizer. A rising edge starts a conversion 2 edges after the first edge that samples it high. A rising edge during a conversion is ignored.
- R9: The address map is: 0 to 3 are result registers, with the result zero-extended on `bus_rdata`; 4 is the control byte. Control byte layout: bit7 done, bit6 interrupt enable, bit5 start, bit4 scan mode, bits2:0 channel. Mode, channel and start may change in one write.
- R10: In scan mode, channels 0, 1, … up to the selected channel are converted back to back, 11 cycles each. Done is set when the selected channel's result is stored, and start stays 1.
- R11: `ana_ch` shows the channel being converted. Channel 1 is field value 3'b001.
- R12: Writing 1 to the start bit during a conversion does not restart it or change its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| ext_trig | input | 1 | Asynchronous conversion trigger |
| cmp_ge | input | 1 | Comparator: input at or above DAC level |
| dac_code | output | 10 | Trial code to the DAC |
| ana_ch | output | 3 | Analog channel select |
| irq | output | 1 | Completion interrupt request |

## Verification
A wrong bit decision in the approximation shows up as a wrong stored value on the very next readback of the result register. The bench sweeps every input level, so each code bit is exercised both kept and dropped. A miscounted bit index or a misplaced store cycle moves the rise of `irq` away from edge 11. The bench checks `irq` one cycle before and at that edge, so such an error is caught on the first conversion. A corrupted read-seen state, channel rotation or synchronizer stage appears at the ports as one of three things: `irq` staying high, results landing in the wrong register, or a completion shifted by a cycle. Each of these is caught within one conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BIT   = 2'd1,
        PH_STORE = 2'd2
    } sar_phase_e;

    localparam int CSR_W   = 8;
    localparam int B_DONE  = 7;
    localparam int B_IE    = 6;
    localparam int B_START = 5;
    localparam int B_SCAN  = 4;
endpackage

// File: rtl/sar_trig_sync.sv
module sar_trig_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = trig_i;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise_o = sync_q.s2 & ~sync_q.s3;

    // R8: an edge yields a single-cycle start request
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/sar_approx.sv
module sar_approx
    import sar_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic             cmp_ge_i,
    output logic [RES_W-1:0] code_o,
    output logic             valid_o
);
    localparam int IDX_W = $clog2(RES_W);

    typedef struct packed {
        sar_phase_e       phase;
        logic [IDX_W-1:0] idx;
        logic [RES_W-1:0] code;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        unique case (eng_q.phase)
            PH_BIT: begin
                if (!cmp_ge_i) eng_d.code[eng_q.idx] = 1'b0;
                if (eng_q.idx == '0) begin
                    eng_d.phase = PH_STORE;
                end else begin
                    eng_d.idx = eng_q.idx - 1'b1;
                    eng_d.code[eng_d.idx] = 1'b1;
                end
            end
            PH_STORE: eng_d.phase = PH_IDLE;
            default:  eng_d.phase = PH_IDLE;
        endcase
        if (start_i && eng_q.phase != PH_BIT) begin
            eng_d.phase = PH_BIT;
            eng_d.idx   = IDX_W'(RES_W - 1);
            eng_d.code  = '0;
            eng_d.code[RES_W-1] = 1'b1;
        end
        if (abort_i) begin
            eng_d.phase = PH_IDLE;
            eng_d.idx   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '{phase: PH_IDLE, idx: '0, code: '0};
        else        eng_q <= eng_d;
    end

    assign code_o  = eng_q.code;
    assign valid_o = (eng_q.phase == PH_STORE);

    // R2: index steps down by exactly one per bit cycle
    a_r2_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.phase == PH_BIT && eng_q.idx != '0 && !abort_i)
        |=> (eng_q.phase == PH_BIT && eng_q.idx == IDX_W'($past(eng_q.idx) - 1'b1)));
    // R2: the store cycle only follows the last bit decision
    a_r2_store_after_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.phase == PH_STORE) |-> $past(eng_q.phase == PH_BIT && eng_q.idx == '0));
endmodule

// File: rtl/sar_result_bank.sv
module sar_result_bank #(
    parameter int NREG  = 4,
    parameter int RES_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [$clog2(NREG)-1:0] widx_i,
    input  logic [RES_W-1:0]        wdata_i,
    input  logic [$clog2(NREG)-1:0] ridx_i,
    output logic [RES_W-1:0]        rdata_o
);
    logic [RES_W-1:0] regs_d [NREG];
    logic [RES_W-1:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        assign regs_d[g] = (we_i && widx_i == g) ? wdata_i : regs_q[g];

        // R4: only the addressed register may change
        a_r4_untouched: assert property (@(posedge clk) disable iff (!rst_n)
            !(we_i && widx_i == g) |=> $stable(regs_q[g]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
        end
    end

    assign rdata_o = regs_q[ridx_i];
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_pkg::*;
#(
    parameter int RES_W    = 10,
    parameter int CH_W     = 3,
    parameter int NREG     = 4,
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 16,
    parameter int CSR_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CSR_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_trig,
    input  logic              cmp_ge,
    output logic [RES_W-1:0]  dac_code,
    output logic [CH_W-1:0]   ana_ch,
    output logic              irq
);
    localparam int RIDX_W = $clog2(NREG);

    typedef struct packed {
        logic            done;
        logic            ie;
        logic            start;
        logic            scan;
        logic            seen;
        logic [CH_W-1:0] sel;
        logic [CH_W-1:0] cur;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             trig_rise;
    logic             eng_start, eng_abort, eng_valid;
    logic [RES_W-1:0] eng_code;
    logic             res_we;
    logic [RES_W-1:0] bank_rd;
    logic             csr_wr, csr_rd, go;
    logic [CSR_W-1:0] csr_view;
    logic             unused_rsvd;

    assign unused_rsvd = bus_wdata[B_SCAN-1];

    sar_trig_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (ext_trig),
        .rise_o (trig_rise)
    );

    sar_approx #(.RES_W(RES_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (eng_start),
        .abort_i  (eng_abort),
        .cmp_ge_i (cmp_ge),
        .code_o   (eng_code),
        .valid_o  (eng_valid)
    );

    sar_result_bank #(.NREG(NREG), .RES_W(RES_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (res_we),
        .widx_i  (ctl_q.cur[RIDX_W-1:0]),
        .wdata_i (eng_code),
        .ridx_i  (bus_addr[RIDX_W-1:0]),
        .rdata_o (bank_rd)
    );

    assign csr_wr = bus_wr && (bus_addr == ADDR_W'(CSR_ADDR));
    assign csr_rd = bus_rd && (bus_addr == ADDR_W'(CSR_ADDR));

    always_comb begin
        ctl_d     = ctl_q;
        go        = 1'b0;
        eng_start = 1'b0;
        eng_abort = 1'b0;
        res_we    = 1'b0;
        if (csr_wr) begin
            ctl_d.ie   = bus_wdata[B_IE];
            ctl_d.scan = bus_wdata[B_SCAN];
            ctl_d.sel  = bus_wdata[CH_W-1:0];
            ctl_d.seen = 1'b0;
            if (!bus_wdata[B_DONE] && ctl_q.seen) ctl_d.done = 1'b0;
            if (bus_wdata[B_START] && !ctl_q.start) go = 1'b1;
            if (!bus_wdata[B_START] && ctl_q.start) begin
                eng_abort   = 1'b1;
                ctl_d.start = 1'b0;
            end
        end
        if (trig_rise && !ctl_q.start) go = 1'b1;
        if (go) begin
            ctl_d.start = 1'b1;
            ctl_d.cur   = ctl_d.scan ? '0 : ctl_d.sel;
            eng_start   = 1'b1;
        end
        if (eng_valid && !eng_abort) begin
            res_we = 1'b1;
            if (ctl_q.scan) begin
                eng_start = 1'b1;
                if (ctl_q.cur >= ctl_q.sel) begin
                    ctl_d.done = 1'b1;
                    ctl_d.cur  = '0;
                end else begin
                    ctl_d.cur = ctl_q.cur + 1'b1;
                end
            end else begin
                ctl_d.done  = 1'b1;
                ctl_d.start = 1'b0;
            end
        end
        if (csr_rd && ctl_q.done) ctl_d.seen = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        csr_view          = '0;
        csr_view[B_DONE]  = ctl_q.done;
        csr_view[B_IE]    = ctl_q.ie;
        csr_view[B_START] = ctl_q.start;
        csr_view[B_SCAN]  = ctl_q.scan;
        csr_view[CH_W-1:0] = ctl_q.sel;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr < ADDR_W'(NREG))            bus_rdata = DATA_W'(bank_rd);
        else if (bus_addr == ADDR_W'(CSR_ADDR))  bus_rdata = DATA_W'(csr_view);
    end

    assign dac_code = eng_code;
    assign ana_ch   = ctl_q.cur;
    assign irq      = ctl_q.done & ctl_q.ie;

    // R4: done only rises on a result-store cycle
    a_r4_done_with_store: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.done) |-> $past(res_we));
    // R6: done only falls after a qualifying status read
    a_r6_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q.done) |-> ($past(ctl_q.seen) && $past(csr_wr)));
    // R3: start only drops at a store or a control write
    a_r3_start_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q.start) |-> $past(res_we || csr_wr));
    // R7: an abort never writes a result
    a_r7_abort_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |-> !res_we);
    // R10: the scan channel never passes the selected limit while scanning
    a_r10_scan_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.scan && ctl_q.start && $stable(ctl_q.sel) && ctl_q.cur <= ctl_q.sel)
        |=> (ctl_q.cur <= ctl_q.sel || !ctl_q.start || !ctl_q.scan));
endmodule

// File: tb/sar_adc_ctrl_test.sv
`timescale 1ns/1ps
module sar_adc_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_trig = 1'b0;
    logic        cmp_ge;
    logic [9:0]  dac_code;
    logic [2:0]  ana_ch;
    logic        irq;

    int vin [8];
    int exp_reg [4];
    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign cmp_ge = vin[ana_ch] >= int'(dac_code);

    sar_adc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_trig(ext_trig), .cmp_ge(cmp_ge), .dac_code(dac_code),
        .ana_ch(ana_ch), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = int'(bus_rdata);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int v;
        for (int i = 0; i < 8; i++) vin[i] = 0;
        for (int i = 0; i < 4; i++) exp_reg[i] = 0;
        wait_n(3);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check(v == 0, "R1 register after reset", v, 0);
        end
        check(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
        check(dac_code == 10'd0, "R1 dac after reset", int'(dac_code), 0);
        check(ana_ch == 3'd0, "R1 ana_ch after reset", int'(ana_ch), 0);

        // R3, R9, R11: channel 1 in single mode, start visible during conversion
        vin[1] = 613;
        wr(3'd4, 8'h61);
        rd(3'd4, v);
        check(v == 'h61, "R3 start bit reads 1 while converting", v, 'h61);
        check(ana_ch == 3'd1, "R11 channel 1 selected", int'(ana_ch), 1);
        wait_n(9);
        check(irq == 1'b1, "R5 irq at completion", int'(irq), 1);
        // R6: clear attempts without a qualifying read
        wr(3'd4, 8'h41);
        check(irq == 1'b1, "R6 zero write without read keeps done", int'(irq), 1);
        rd(3'd4, v);
        check(v == 'hC1, "R3 start cleared, done set", v, 'hC1);
        wr(3'd4, 8'hC1);
        check(irq == 1'b1, "R6 writing 1 to done keeps it", int'(irq), 1);
        wr(3'd4, 8'h41);
        check(irq == 1'b1, "R6 read consumed by earlier write", int'(irq), 1);
        rd(3'd4, v);
        wr(3'd4, 8'h41);
        check(irq == 1'b0, "R6 read then zero write clears", int'(irq), 0);
        rd(3'd4, v);
        check(v == 'h41, "R6 done bit cleared", v, 'h41);
        rd(3'd1, v);
        check(v == 613, "R4 result in register 1", v, 613);
        exp_reg[1] = 613;

        // R2, R4, R5, R11: sweep every level over all channels
        for (int lv = 0; lv < 1024; lv++) begin
            int ch;
            ch = lv % 8;
            vin[ch] = (lv == 1023) ? 1500 : lv;
            wr(3'd4, 8'(8'h60 | ch));
            wait_n(5);
            check(ana_ch == 3'(ch), "R11 ana_ch during conversion", int'(ana_ch), ch);
            wait_n(5);
            check(irq == 1'b0, "R2 not done before edge 11", int'(irq), 0);
            wait_n(1);
            check(irq == 1'b1, "R5 irq at edge 11", int'(irq), 1);
            rd(3'(ch % 4), v);
            check(v == lv, "R2 converted value", v, lv);
            exp_reg[ch % 4] = lv;
            rd(3'd4, v);
            check(v == (8'hC0 | ch), "R4 done set, start clear", v, 8'hC0 | ch);
            wr(3'd4, 8'(8'h40 | ch));
            check(irq == 1'b0, "R5 irq drops with done", int'(irq), 0);
        end

        // R7: abort during conversion
        vin[3] = 777;
        wr(3'd4, 8'h63);
        wait_n(4);
        wr(3'd4, 8'h43);
        wait_n(15);
        rd(3'd3, v);
        check(v == exp_reg[3], "R7 abort leaves result", v, exp_reg[3]);
        check(irq == 1'b0, "R7 abort sets no done", int'(irq), 0);
        rd(3'd4, v);
        check(v == 'h43, "R7 start cleared by abort", v, 'h43);

        // R12: rewriting start mid-conversion keeps timing
        vin[2] = 300;
        wr(3'd4, 8'h62);
        wait_n(3);
        wr(3'd4, 8'h62);
        wait_n(5);
        check(irq == 1'b0, "R12 not done before edge 11", int'(irq), 0);
        wait_n(1);
        check(irq == 1'b1, "R12 done at original edge 11", int'(irq), 1);
        rd(3'd2, v);
        check(v == 300, "R12 result", v, 300);
        rd(3'd4, v);
        wr(3'd4, 8'h40);
        check(irq == 1'b0, "R6 cleared before trigger test", int'(irq), 0);

        // R8: trigger start latency and mid-conversion edge ignored
        vin[0] = 123;
        ext_trig = 1'b1;
        wait_n(4);
        ext_trig = 1'b0;
        wait_n(2);
        ext_trig = 1'b1;
        wait_n(7);
        check(irq == 1'b0, "R8 not done before edge 13", int'(irq), 0);
        wait_n(1);
        check(irq == 1'b1, "R8 done at edge 13", int'(irq), 1);
        wait_n(20);
        rd(3'd4, v);
        check(v == 'hC0, "R8 second edge ignored", v, 'hC0);
        rd(3'd0, v);
        check(v == 123, "R8 triggered result", v, 123);
        ext_trig = 1'b0;
        wr(3'd4, 8'h40);
        check(irq == 1'b0, "R6 clear after trigger", int'(irq), 0);

        // R10: scan over channels 0..2
        vin[0] = 100; vin[1] = 200; vin[2] = 300;
        wr(3'd4, 8'h72);
        wait_n(5);
        check(ana_ch == 3'd0, "R10 first channel 0", int'(ana_ch), 0);
        wait_n(11);
        check(ana_ch == 3'd1, "R10 then channel 1", int'(ana_ch), 1);
        wait_n(11);
        check(ana_ch == 3'd2, "R10 then channel 2", int'(ana_ch), 2);
        wait_n(5);
        check(irq == 1'b0, "R10 no done before pass ends", int'(irq), 0);
        wait_n(2);
        check(irq == 1'b1, "R10 done after pass", int'(irq), 1);
        wait_n(4);
        check(ana_ch == 3'd0, "R10 wraps to channel 0", int'(ana_ch), 0);
        rd(3'd4, v);
        check(v == 'hF2, "R10 start stays set in scan", v, 'hF2);
        wr(3'd4, 8'h52);
        check(irq == 1'b0, "R7 scan stopped and done cleared", int'(irq), 0);
        for (int c = 0; c < 3; c++) begin
            rd(3'(c), v);
            check(v == 100 * (c + 1), "R10 scan result", v, 100 * (c + 1));
        end
        rd(3'd4, v);
        check(v == 'h52, "R10 idle after stop", v, 'h52);

        // R11: channel 5 shares register 1
        vin[5] = 555;
        wr(3'd4, 8'h45);
        wr(3'd4, 8'h65);
        wait_n(11);
        rd(3'd1, v);
        check(v == 555, "R4 channel 5 into register 1", v, 555);

        finish_run();
    end
endmodule